// File: doc/BRIEF.md
# Quad Line Thermal-Protection Enable Controller

This block is the digital control core behind four switched line-feed drivers. Software supplies a per-line enable word and an interrupt-enable bit. The analog side supplies raw per-line current-overload flags and two over-temperature flags: a warm threshold and a hot threshold. From these inputs the block decides which driver switches are closed. It keeps a latched per-line trip word, raises a global over-temperature flag and drives an active-low, level-sensitive interrupt. All analog flags come in asynchronously and pass through two-flop synchronizers before any logic uses them.

At the warm threshold, only the lines that currently report overload are opened, and their trip bits are latched. At the hot threshold, every line is opened and every trip bit is latched. A latched trip bit clears only after software has removed the enable for that line. Clearing is blocked while any trip condition still holds. Software may then enable the line again. The interrupt reflects overload only on lines whose switch is actually closed.

Top module: `line_thermal_ctrl`

## Requirements
- R1: `drv_on[i]` is 1 only when `en_word[i]` is 1 and `line_ok[i]` is 1 (1 = operational) and no trip condition holds on line i. With no temperature flag active and every `line_ok` bit at 1, `drv_on` equals `en_word`.
- R2: While the synchronized warm flag is 1, each line whose synchronized overload bit is 1 is switched off at once. Its `line_ok` bit goes to 0 on the next clock. Lines without overload are not affected.
- R3: While the synchronized hot flag is 1, all `drv_on` bits are 0, all `line_ok` bits go to 0 and `overtemp` is 1.
- R4: `overtemp` returns to 0 once the hot flag is released. While the hot flag is active, no `line_ok` bit returns to 1, even if its enable bit is 0.
- R5: A cleared `line_ok` bit returns to 1 one clock after its enable bit has been written to 0, provided no trip condition holds. Other tripped lines stay cleared. Afterwards the line can be enabled again.
- R6: `line_ok` is latched. When the overload and temperature flags drop, a tripped line stays off as long as its enable bit remains 1.
- R7: `irq_n` is 0 exactly when the interrupt enable is 1 and at least one line has both its synchronized overload bit and its `drv_on` bit at 1. It is not latched and returns to 1 as soon as no such line remains.
- R8: An overloaded line that software has disabled, or that has been shut off thermally, does not pull `irq_n` low.
- R9: After reset, `drv_on` is 0, `en_word` is 0, the interrupt enable is 0, `irq_n` is 1, `line_ok` is all ones and `overtemp` is 0.
- R10: `ovl_status` shows the raw overload inputs after two clocks of synchronization, with no latching. Temperature flags take effect with the same two-clock delay.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| en_we | input | 1 | Write strobe for the line-enable word |
| en_wdata | input | 4 | New line-enable word, bit i for line i |
| ien_we | input | 1 | Write strobe for the interrupt enable |
| ien_wdata | input | 1 | New interrupt-enable value |
| ovl_async | input | 4 | Raw per-line current-overload flags, asynchronous |
| warm_async | input | 1 | Lower temperature threshold flag, asynchronous |
| hot_async | input | 1 | Upper temperature threshold flag, asynchronous |
| en_word | output | 4 | Current line-enable word |
| drv_on | output | 4 | Driver switch closed, per line (switch-state status word) |
| line_ok | output | 4 | Latched thermal trip word, 1 = operational, 0 = tripped |
| overtemp | output | 1 | Global over-temperature flag |
| ovl_status | output | 4 | Synchronized overload flags, unlatched |
| irq_n | output | 1 | Active-low overload interrupt |

## Verification
The bench builds the block with its default of four lines and two synchronizer stages. At that size every combination of enable word, overload word and interrupt enable can be swept: 512 cases, each checked for switch state, interrupt level and pass-through status. The four lines also keep all fifteen non-empty overload subsets within reach for warm-threshold trips. Each of those subsets is driven through trip, latch and re-arm. Directed sequences cover partial re-arming, the hot threshold blocking re-arm, and reset in the middle of a trip.

// File: rtl/ltc_pkg.sv
package ltc_pkg;

  // Per-line trip condition from synchronized flags.
  function automatic logic ltc_trip(input logic warm, input logic hot, input logic ovl);
    return hot | (warm & ovl);
  endfunction

  // Closed-switch decision for one line.
  function automatic logic ltc_drive(input logic en, input logic ok, input logic trip);
    return en & ok & ~trip;
  endfunction

  // Active-high interrupt level from qualified overload bits.
  function automatic logic ltc_irq_level(input logic ien, input logic [31:0] qualified);
    return ien & (|qualified);
  endfunction

endpackage

// File: rtl/ltc_sync.sv
module ltc_sync #(
  parameter int WIDTH  = 4,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] d_async,
  output logic [WIDTH-1:0] q_sync
);

  logic [WIDTH-1:0] stage_q [STAGES];

  genvar s;
  generate
    for (s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
        always_ff @(posedge clk) begin
          if (rst) stage_q[0] <= '0;
          else     stage_q[0] <= d_async;
        end
      end else begin : g_next
        always_ff @(posedge clk) begin
          if (rst) stage_q[s] <= '0;
          else     stage_q[s] <= stage_q[s-1];
        end
      end
    end
  endgenerate

  assign q_sync = stage_q[STAGES-1];

endmodule

// File: rtl/ltc_sw_regs.sv
module ltc_sw_regs #(
  parameter int LINES = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             en_we,
  input  logic [LINES-1:0] en_wdata,
  input  logic             ien_we,
  input  logic             ien_wdata,
  output logic [LINES-1:0] en_q,
  output logic             ien_q
);

  always_ff @(posedge clk) begin
    if (rst) begin
      en_q  <= '0;
      ien_q <= 1'b0;
    end else begin
      if (en_we)  en_q  <= en_wdata;
      if (ien_we) ien_q <= ien_wdata;
    end
  end

  // R9
  ien_reset_chk: assert property (@(posedge clk) rst |=> (ien_q == 1'b0 && en_q == '0));

endmodule

// File: rtl/ltc_line_slice.sv
module ltc_line_slice
  import ltc_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic en_bit,
  input  logic ovl_bit,
  input  logic warm,
  input  logic hot,
  output logic ok_q,
  output logic drv,
  output logic trip_now
);

  logic rearm_ok;

  assign trip_now = ltc_trip(warm, hot, ovl_bit);
  assign rearm_ok = ~en_bit & ~ok_q & ~trip_now;
  assign drv      = ltc_drive(en_bit, ok_q, trip_now);

  always_ff @(posedge clk) begin
    if (rst)           ok_q <= 1'b1;
    else if (trip_now) ok_q <= 1'b0;
    else if (rearm_ok) ok_q <= 1'b1;
  end

  // R1
  drv_gate_chk: assert property (@(posedge clk) disable iff (rst) drv |-> (en_bit && ok_q));
  // R2
  warm_trip_chk: assert property (@(posedge clk) disable iff (rst) (warm && ovl_bit) |=> !ok_q);
  // R3
  hot_off_chk: assert property (@(posedge clk) disable iff (rst) hot |-> !drv);
  // R4
  hot_hold_chk: assert property (@(posedge clk) disable iff (rst) hot |=> !ok_q);
  // R5
  rearm_needs_off_chk: assert property (@(posedge clk) disable iff (rst) $rose(ok_q) |-> $past(!en_bit));
  // R6
  trip_latched_chk: assert property (@(posedge clk) disable iff (rst) (!ok_q && en_bit) |=> !ok_q);

endmodule

// File: rtl/line_thermal_ctrl.sv
module line_thermal_ctrl
  import ltc_pkg::*;
#(
  parameter int LINES       = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             en_we,
  input  logic [LINES-1:0] en_wdata,
  input  logic             ien_we,
  input  logic             ien_wdata,
  input  logic [LINES-1:0] ovl_async,
  input  logic             warm_async,
  input  logic             hot_async,
  output logic [LINES-1:0] en_word,
  output logic [LINES-1:0] drv_on,
  output logic [LINES-1:0] line_ok,
  output logic             overtemp,
  output logic [LINES-1:0] ovl_status,
  output logic             irq_n
);

  localparam int SYNC_W = LINES + 2;

  logic [SYNC_W-1:0] raw_bus, sync_bus;
  logic [LINES-1:0]  ovl_s;
  logic              warm_s, hot_s;
  logic              ien_q;
  logic [LINES-1:0]  trip_vec;
  logic [LINES-1:0]  qualified_ovl;

  assign raw_bus = {hot_async, warm_async, ovl_async};

  ltc_sync #(.WIDTH(SYNC_W), .STAGES(SYNC_STAGES)) u_sync (
    .clk     (clk),
    .rst     (rst),
    .d_async (raw_bus),
    .q_sync  (sync_bus)
  );

  assign ovl_s  = sync_bus[LINES-1:0];
  assign warm_s = sync_bus[LINES];
  assign hot_s  = sync_bus[LINES+1];

  ltc_sw_regs #(.LINES(LINES)) u_regs (
    .clk       (clk),
    .rst       (rst),
    .en_we     (en_we),
    .en_wdata  (en_wdata),
    .ien_we    (ien_we),
    .ien_wdata (ien_wdata),
    .en_q      (en_word),
    .ien_q     (ien_q)
  );

  genvar i;
  generate
    for (i = 0; i < LINES; i++) begin : g_line
      ltc_line_slice u_slice (
        .clk      (clk),
        .rst      (rst),
        .en_bit   (en_word[i]),
        .ovl_bit  (ovl_s[i]),
        .warm     (warm_s),
        .hot      (hot_s),
        .ok_q     (line_ok[i]),
        .drv      (drv_on[i]),
        .trip_now (trip_vec[i])
      );
    end
  endgenerate

  assign qualified_ovl = ovl_s & drv_on;
  assign irq_n         = ~ltc_irq_level(ien_q, 32'(qualified_ovl));
  assign overtemp      = hot_s;
  assign ovl_status    = ovl_s;

  // R7
  irq_needs_enable_chk: assert property (@(posedge clk) disable iff (rst) !irq_n |-> ien_q);
  // R8
  irq_needs_live_line_chk: assert property (@(posedge clk) disable iff (rst) !irq_n |-> (|(ovl_s & drv_on)));
  // R3
  overtemp_all_off_chk: assert property (@(posedge clk) disable iff (rst) overtemp |-> (drv_on == '0));
  // R2
  trip_opens_chk: assert property (@(posedge clk) disable iff (rst) ((trip_vec & drv_on) == '0));

endmodule

// File: tb/line_thermal_ctrl_test.sv
module line_thermal_ctrl_test;

  logic       clk = 1'b0;
  logic       rst;
  logic       en_we, ien_we, ien_wdata;
  logic [3:0] en_wdata, ovl_async;
  logic       warm_async, hot_async;
  logic [3:0] en_word, drv_on, line_ok, ovl_status;
  logic       overtemp, irq_n;

  int checks = 0;
  int errors = 0;

  always #10 clk = ~clk;

  line_thermal_ctrl uut (
    .clk(clk), .rst(rst), .en_we(en_we), .en_wdata(en_wdata),
    .ien_we(ien_we), .ien_wdata(ien_wdata), .ovl_async(ovl_async),
    .warm_async(warm_async), .hot_async(hot_async), .en_word(en_word),
    .drv_on(drv_on), .line_ok(line_ok), .overtemp(overtemp),
    .ovl_status(ovl_status), .irq_n(irq_n)
  );

  task automatic check(input string tag, input logic [3:0] act, input logic [3:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %b expected %b at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic write_en(input logic [3:0] v);
    en_we = 1'b1; en_wdata = v;
    step(1);
    en_we = 1'b0;
  endtask

  task automatic write_ien(input logic v);
    ien_we = 1'b1; ien_wdata = v;
    step(1);
    ien_we = 1'b0;
  endtask

  task automatic do_reset();
    rst = 1'b1;
    step(2);
    rst = 1'b0;
  endtask

  function automatic logic exp_irq(input logic ien, input logic [3:0] ovl, input logic [3:0] drv);
    return !(ien && ((ovl & drv) != 4'b0000));
  endfunction

  initial begin
    #(20 * 100000);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    en_we = 0; ien_we = 0; ien_wdata = 0; en_wdata = 0;
    ovl_async = 0; warm_async = 0; hot_async = 0;
    rst = 1'b1;
    @(negedge clk);
    do_reset();

    // R9 reset state
    check("R9 drv_on", drv_on, 4'b0000);
    check("R9 en_word", en_word, 4'b0000);
    check("R9 line_ok", line_ok, 4'b1111);
    check("R9 irq_n", {3'b0, irq_n}, 4'b0001);
    check("R9 overtemp", {3'b0, overtemp}, 4'b0000);
    ovl_async = 4'b1111;
    step(3);
    check("R9 irq inactive after reset", {3'b0, irq_n}, 4'b0001);

    // R1 R7 R8 R10 sweep without temperature flags
    for (int b = 0; b < 2; b++) begin
      write_ien(b[0]);
      for (int e = 0; e < 16; e++) begin
        write_en(e[3:0]);
        for (int o = 0; o < 16; o++) begin
          ovl_async = o[3:0];
          step(3);
          check("R1 drv_on follows enable", drv_on, e[3:0]);
          check("R10 ovl_status", ovl_status, o[3:0]);
          check("R7 R8 irq_n level", {3'b0, irq_n}, {3'b0, exp_irq(b[0], o[3:0], e[3:0])});
        end
      end
    end
    ovl_async = 0;
    step(3);
    check("R7 irq released", {3'b0, irq_n}, 4'b0001);

    // R10 two-clock latency
    ovl_async = 4'b0101;
    step(1);
    check("R10 not yet after one clock", ovl_status, 4'b0000);
    step(1);
    check("R10 visible after two clocks", ovl_status, 4'b0101);
    ovl_async = 0;
    step(2);

    // R2 R5 R6 R8 warm trip of every overload subset
    write_ien(1'b1);
    for (int o = 1; o < 16; o++) begin
      write_en(4'b1111);
      warm_async = 1'b1; ovl_async = o[3:0];
      step(3);
      check("R2 tripped lines cleared", line_ok, ~o[3:0]);
      check("R2 tripped lines off", drv_on, ~o[3:0]);
      check("R8 tripped line no irq", {3'b0, irq_n}, 4'b0001);
      warm_async = 1'b0; ovl_async = 4'b0000;
      step(3);
      check("R6 trip stays latched", line_ok, ~o[3:0]);
      check("R6 line stays off", drv_on, ~o[3:0]);
      write_en(~o[3:0]);
      step(1);
      check("R5 re-armed after disable", line_ok, 4'b1111);
      write_en(4'b1111);
      check("R5 re-enable closes switch", drv_on, 4'b1111);
    end

    // R5 partial re-arm
    warm_async = 1'b1; ovl_async = 4'b0011;
    step(3);
    warm_async = 1'b0; ovl_async = 4'b0000;
    step(3);
    write_en(4'b1110);
    step(1);
    check("R5 only disabled line re-arms", line_ok, 4'b1101);
    check("R5 partial drv", drv_on, 4'b1100);
    write_en(4'b0000);
    step(1);
    check("R5 second line re-arms", line_ok, 4'b1111);

    // R2 warm flag alone does nothing
    write_en(4'b1111);
    warm_async = 1'b1;
    step(3);
    check("R2 warm without overload", line_ok, 4'b1111);
    check("R2 warm without overload drv", drv_on, 4'b1111);
    warm_async = 1'b0;
    step(2);

    // R3 R4 hot threshold
    hot_async = 1'b1;
    step(3);
    check("R3 all drivers off", drv_on, 4'b0000);
    check("R3 all trips latched", line_ok, 4'b0000);
    check("R3 overtemp set", {3'b0, overtemp}, 4'b0001);
    write_en(4'b0000);
    step(2);
    check("R4 no re-arm while hot", line_ok, 4'b0000);
    hot_async = 1'b0;
    step(2);
    check("R4 overtemp cleared", {3'b0, overtemp}, 4'b0000);
    step(1);
    check("R4 re-arm after hot clears", line_ok, 4'b1111);
    write_en(4'b1010);
    check("R5 re-enable after hot", drv_on, 4'b1010);

    // R9 reset during trip
    hot_async = 1'b1;
    step(3);
    hot_async = 1'b0;
    do_reset();
    check("R9 reset restores line_ok", line_ok, 4'b1111);
    check("R9 reset clears enables", en_word, 4'b0000);
    step(3);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule